// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the two lines of an I2C bus without ever driving them. It brings both lines into the system clock domain and classifies every SDA transition seen while SCL is high as a bus condition. A falling SDA becomes a start, or a repeated start if a transaction is already open. A rising SDA becomes a stop. From these conditions it keeps a bus-busy level and a ready level. The ready level tells a device with queued traffic that the bus has returned to idle and it may open its own transaction.

Every start, repeated or not, also raises a one-cycle wake pulse. The monitor then shifts in the first byte that follows, sampling on the SCL rising edges with the most significant bit first. It presents that byte with a one-cycle valid strobe, so that sleeping logic can compare the address before it powers up anything else. If the bus is left with both lines high for a programmable number of clock cycles, the busy level clears without a stop. This recovers from a master that disappears mid-transfer.

Top module: `i2c_cond_mon`

## Requirements
- R1: After reset, busy_o, ready_o, addr_vld_o and all condition pulses are 0.
- R2: A falling SDA while the synchronised SCL has been high for at least STABLE_SAMPLES prior samples, with the bus idle, gives one start_o pulse. The same event sets busy_o and clears ready_o.
- R3: The same qualified falling SDA while busy_o is 1 gives one rstart_o pulse and no start_o pulse, and busy_o stays 1.
- R4: A qualified rising SDA gives one stop_o pulse. It clears busy_o and sets ready_o.
- R5: wake_o pulses once for each start and for each repeated start.
- R6: SDA changes while SCL is low never produce start_o, rstart_o or stop_o. At most one of those three pulses is high in any cycle.
- R7: An SDA edge that arrives fewer than STABLE_SAMPLES samples after SCL rose is ignored: no pulse, and busy_o does not change.
- R8: The first 8 SCL rising edges after a start sample SDA as the address byte, most significant bit first. addr_vld_o pulses exactly once, on the 8th edge, with addr_o holding the byte. Later bits do not pulse it again.
- R9: Every start or repeated start restarts the bit count, so a repeated start captures a fresh first byte.
- R10: With both lines high for IDLE_TIMEOUT consecutive cycles, busy_o clears and ready_o sets, without a stop_o pulse. Before that many cycles, busy_o stays 1.
- R11: A stop before 8 bits have been clocked abandons the capture, and addr_vld_o does not pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Observed bus clock line |
| sda_i | input | 1 | Observed bus data line |
| start_o | output | 1 | One-cycle pulse: start from an idle bus |
| rstart_o | output | 1 | One-cycle pulse: repeated start while busy |
| stop_o | output | 1 | One-cycle pulse: stop condition |
| wake_o | output | 1 | One-cycle pulse on any start |
| busy_o | output | 1 | A transaction is open |
| ready_o | output | 1 | The bus has returned to idle after a stop or idle timeout |
| addr_o | output | ADDR_BITS | First byte captured after the latest start |
| addr_vld_o | output | 1 | One-cycle strobe when addr_o is updated |

## Verification
The bench builds the monitor with two synchroniser stages, STABLE_SAMPLES of 2 and IDLE_TIMEOUT shortened to 64 cycles. With the short timeout, recovery from an abandoned transaction can be seen within a short run. Holding SCL high for only one sample before moving SDA brings the qualification window to its exact edge. Bit periods of a few clock cycles keep the whole address-and-data sequence affordable, while leaving SCL high long enough to qualify each real start and stop.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

   // Single-cycle condition pulses produced by the classifier
   typedef struct packed {
      logic start;
      logic rstart;
      logic stop;
      logic wake;
   } i2c_cond_t;

   localparam int unsigned LINE_SCL = 0;
   localparam int unsigned LINE_SDA = 1;
   localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_mon_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond
   import i2c_mon_pkg::*;
#(
   parameter int unsigned STABLE_SAMPLES = 2,
   parameter int unsigned IDLE_TIMEOUT   = 2000
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      scl_s_i,
   input  logic      sda_s_i,
   output logic      start_det_o,
   output logic      stop_det_o,
   output logic      scl_rise_o,
   output i2c_cond_t cond_o,
   output logic      busy_o,
   output logic      ready_o
);

   localparam int unsigned CW = $clog2(STABLE_SAMPLES + 1);

   if (STABLE_SAMPLES < 1) begin : g_bad_stable
      $error("i2c_mon_cond: STABLE_SAMPLES must be at least 1");
   end

   logic          scl_d, sda_d;
   logic [CW-1:0] hi_cnt;
   logic          scl_qual;
   logic          idle_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
         hi_cnt <= '0;
      end else begin
         scl_d <= scl_s_i;
         sda_d <= sda_s_i;
         if (!scl_s_i) begin
            hi_cnt <= '0;
         end else if (hi_cnt < CW'(STABLE_SAMPLES)) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
      end
   end

   // SCL counts as high only after enough earlier high samples
   assign scl_qual    = scl_s_i && (hi_cnt >= CW'(STABLE_SAMPLES));
   assign start_det_o = scl_qual && sda_d && !sda_s_i;
   assign stop_det_o  = scl_qual && !sda_d && sda_s_i;
   assign scl_rise_o  = scl_s_i && !scl_d;

   if (IDLE_TIMEOUT > 0) begin : g_idle
      localparam int unsigned TW = $clog2(IDLE_TIMEOUT + 1);
      logic [TW-1:0] idle_cnt;
      logic          both_high;
      assign both_high = scl_s_i && sda_s_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            idle_cnt <= '0;
         end else if (!both_high) begin
            idle_cnt <= '0;
         end else if (idle_cnt < TW'(IDLE_TIMEOUT)) begin
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
      assign idle_hit = both_high && (idle_cnt == TW'(IDLE_TIMEOUT - 1));
   end else begin : g_no_idle
      assign idle_hit = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o  <= 1'b0;
         ready_o <= 1'b0;
         cond_o  <= '0;
      end else begin
         cond_o.start  <= start_det_o && !busy_o;
         cond_o.rstart <= start_det_o && busy_o;
         cond_o.stop   <= stop_det_o;
         cond_o.wake   <= start_det_o;
         if (start_det_o) begin
            busy_o  <= 1'b1;
            ready_o <= 1'b0;
         end else if (stop_det_o || idle_hit) begin
            busy_o  <= 1'b0;
            ready_o <= 1'b1;
         end
      end
   end

   // R2
   start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_o.start |-> (busy_o && !ready_o));
   // R3
   rstart_prior_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_o.rstart |-> $past(busy_o));
   // R4
   stop_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_o.stop |-> (!busy_o && ready_o));
   // R6
   one_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({cond_o.start, cond_o.rstart, cond_o.stop}));
   // R5
   wake_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_o.wake |-> (cond_o.start || cond_o.rstart));

endmodule

// File: rtl/i2c_mon_capture.sv
module i2c_mon_capture #(
   parameter int unsigned ADDR_BITS = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_det_i,
   input  logic                 stop_det_i,
   input  logic                 scl_rise_i,
   input  logic                 sda_s_i,
   output logic [ADDR_BITS-1:0] addr_o,
   output logic                 addr_vld_o
);

   localparam int unsigned BW = $clog2(ADDR_BITS + 1);

   if (ADDR_BITS < 2) begin : g_bad_bits
      $error("i2c_mon_capture: ADDR_BITS must be at least 2");
   end

   logic [BW-1:0]        bit_cnt;
   logic                 active;
   logic [ADDR_BITS-2:0] shift_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_cnt    <= '0;
         active     <= 1'b0;
         shift_q    <= '0;
         addr_o     <= '0;
         addr_vld_o <= 1'b0;
      end else begin
         addr_vld_o <= 1'b0;
         if (start_det_i) begin
            bit_cnt <= '0;
            active  <= 1'b1;
         end else if (stop_det_i) begin
            active <= 1'b0;
         end else if (scl_rise_i && active) begin
            shift_q <= {shift_q[ADDR_BITS-3:0], sda_s_i};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BW'(ADDR_BITS - 1)) begin
               active     <= 1'b0;
               addr_o     <= {shift_q, sda_s_i};
               addr_vld_o <= 1'b1;
            end
         end
      end
   end

   // R8
   vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_vld_o |=> !addr_vld_o);

endmodule

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon
   import i2c_mon_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned STABLE_SAMPLES = 2,
   parameter int unsigned IDLE_TIMEOUT   = 2000,
   parameter int unsigned ADDR_BITS      = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 start_o,
   output logic                 rstart_o,
   output logic                 stop_o,
   output logic                 wake_o,
   output logic                 busy_o,
   output logic                 ready_o,
   output logic [ADDR_BITS-1:0] addr_o,
   output logic                 addr_vld_o
);

   logic [NUM_LINES-1:0] raw_lines, sync_lines;
   logic                 start_det, stop_det, scl_rise;
   i2c_cond_t            cond;

   assign raw_lines[LINE_SCL] = scl_i;
   assign raw_lines[LINE_SDA] = sda_i;

   for (genvar li = 0; li < NUM_LINES; li++) begin : g_sync
      i2c_mon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .d_i   (raw_lines[li]),
         .q_o   (sync_lines[li])
      );
   end

   i2c_mon_cond #(.STABLE_SAMPLES(STABLE_SAMPLES), .IDLE_TIMEOUT(IDLE_TIMEOUT)) cond_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_s_i    (sync_lines[LINE_SCL]),
      .sda_s_i    (sync_lines[LINE_SDA]),
      .start_det_o(start_det),
      .stop_det_o (stop_det),
      .scl_rise_o (scl_rise),
      .cond_o     (cond),
      .busy_o     (busy_o),
      .ready_o    (ready_o)
   );

   i2c_mon_capture #(.ADDR_BITS(ADDR_BITS)) cap_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_det_i(start_det),
      .stop_det_i (stop_det),
      .scl_rise_i (scl_rise),
      .sda_s_i    (sync_lines[LINE_SDA]),
      .addr_o     (addr_o),
      .addr_vld_o (addr_vld_o)
   );

   assign start_o  = cond.start;
   assign rstart_o = cond.rstart;
   assign stop_o   = cond.stop;
   assign wake_o   = cond.wake;

   // R4
   busy_ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(busy_o && ready_o));

endmodule

// File: tb/i2c_cond_mon_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_mon_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       start_p, rstart_p, stop_p, wake_p, busy, ready, vld;
   logic [7:0] addr;

   int n_chk = 0;
   int n_fail = 0;
   int c_start = 0, c_rstart = 0, c_stop = 0, c_wake = 0, c_vld = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   i2c_cond_mon #(.SYNC_STAGES(2), .STABLE_SAMPLES(2), .IDLE_TIMEOUT(64), .ADDR_BITS(8)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
      .start_o(start_p), .rstart_o(rstart_p), .stop_o(stop_p), .wake_o(wake_p),
      .busy_o(busy), .ready_o(ready), .addr_o(addr), .addr_vld_o(vld)
   );

   always @(negedge clk) begin
      if (start_p)  c_start++;
      if (rstart_p) c_rstart++;
      if (stop_p)   c_stop++;
      if (wake_p)   c_wake++;
      if (vld)      c_vld++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_start();
      scl = 1'b1; sda = 1'b1; tick(5);
      sda = 1'b0; tick(5);
      scl = 1'b0; tick(3);
   endtask

   task automatic do_rstart();
      scl = 1'b0; tick(2);
      sda = 1'b1; tick(3);
      scl = 1'b1; tick(5);
      sda = 1'b0; tick(5);
      scl = 1'b0; tick(3);
   endtask

   task automatic do_stop();
      scl = 1'b0; tick(2);
      sda = 1'b0; tick(3);
      scl = 1'b1; tick(5);
      sda = 1'b1; tick(6);
   endtask

   task automatic send_bit(input logic b);
      scl = 1'b0; tick(2);
      sda = b; tick(3);
      scl = 1'b1; tick(5);
      scl = 1'b0; tick(2);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      send_bit(1'b1);
      tick(3);
   endtask

   task automatic t_reset();
      chk("R1", "busy", busy, 0);
      chk("R1", "ready", ready, 0);
      chk("R1", "pulses", c_start + c_rstart + c_stop + c_wake + c_vld, 0);
   endtask

   task automatic t_write();
      int s0 = c_start, r0 = c_rstart, p0 = c_stop, w0 = c_wake, v0 = c_vld;
      do_start();
      chk("R2", "start pulses", c_start - s0, 1);
      chk("R2", "busy", busy, 1);
      chk("R2", "ready", ready, 0);
      chk("R5", "wake pulses", c_wake - w0, 1);
      send_byte(8'hA6);
      chk("R8", "addr valid pulses", c_vld - v0, 1);
      chk("R8", "addr", addr, 8'hA6);
      send_byte(8'h3C);
      chk("R6", "conditions during data", (c_start - s0) + (c_rstart - r0) + (c_stop - p0), 1);
      chk("R8", "no extra valid", c_vld - v0, 1);
      do_stop();
      chk("R4", "stop pulses", c_stop - p0, 1);
      chk("R4", "busy", busy, 0);
      chk("R4", "ready", ready, 1);
   endtask

   task automatic t_rstart();
      int s0 = c_start, r0 = c_rstart, w0 = c_wake, v0 = c_vld;
      do_start();
      send_byte(8'h50);
      do_rstart();
      chk("R3", "rstart pulses", c_rstart - r0, 1);
      chk("R3", "start pulses", c_start - s0, 1);
      chk("R3", "busy", busy, 1);
      chk("R5", "wake pulses", c_wake - w0, 2);
      send_byte(8'h51);
      chk("R9", "valid pulses", c_vld - v0, 2);
      chk("R9", "addr", addr, 8'h51);
      do_stop();
   endtask

   task automatic t_partial();
      int v0 = c_vld;
      do_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      do_stop();
      tick(4);
      chk("R11", "valid after short frame", c_vld - v0, 0);
      do_start();
      send_byte(8'h1E);
      chk("R9", "addr after fresh start", addr, 8'h1E);
      chk("R9", "valid pulses", c_vld - v0, 1);
      do_stop();
   endtask

   task automatic t_glitch();
      int s0 = c_start, w0 = c_wake;
      scl = 1'b0; tick(3);
      sda = 1'b1; tick(3);
      scl = 1'b1; tick(1);
      sda = 1'b0; tick(8);
      chk("R7", "start pulses", c_start - s0, 0);
      chk("R7", "wake pulses", c_wake - w0, 0);
      chk("R7", "busy", busy, 0);
      scl = 1'b0; tick(3);
      sda = 1'b1; tick(3);
      scl = 1'b1; tick(5);
   endtask

   task automatic t_timeout();
      int p0 = c_stop;
      do_start();
      scl = 1'b0; tick(2);
      sda = 1'b1; tick(3);
      scl = 1'b1; tick(20);
      chk("R10", "busy before timeout", busy, 1);
      tick(60);
      chk("R10", "busy after timeout", busy, 0);
      chk("R10", "ready after timeout", ready, 1);
      chk("R10", "no stop pulse", c_stop - p0, 0);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(3);
      t_reset();
      t_write();
      t_rstart();
      t_partial();
      t_glitch();
      t_timeout();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule